// File: doc/BRIEF.md
# Asynchronous SAR Comparator-Clock Sequencer

This block paces the comparator of an asynchronous successive-approximation converter. It is modelled in a fast oversampling clock domain. While the sampling clock is low the conversion runs. The block raises the comparator clock and waits for the comparator to report a decision. It then drops the clock straight away through a fast reset path. Once the comparator clears its done flag, the block waits through a programmable settling interval and raises the clock again.

The settling interval is the time the capacitor DAC needs to settle. It is set by a 5-bit code in linear steps above a nonzero floor. A bit index tells an external approximation register which decision is being made. A strobe marks the cycle in which that decision is valid. After the last decision the block runs one more settling interval as timing margin and then raises an end-of-conversion flag. A conversion that is cut short by the sampling clock is abandoned.

Top module: `async_sar_sequencer`

## Requirements
- R1: While `rst_n` is low, `cmp_clk`, `conv_stop` and `bit_strobe` are 0 and `bit_idx` equals NBITS-1.
- R2: When the sequencer is idle and `samp_clk` is sampled low at a clock edge, `cmp_clk` is high after that same edge.
- R3: While `cmp_clk` is high, `cmp_done` high makes `bit_strobe` high in that same cycle, combinationally, and `cmp_clk` is low after the next clock edge.
- R4: If `cmp_done` is first sampled low at edge E after a decision, and more decisions remain, `cmp_clk` rises at edge E + MIN_TICKS + code × STEP_TICKS, where code is `dly_code` read as an unsigned number.
- R5: Every settling wait starts from zero. This holds for the first wait after an aborted conversion too, so no wait is ever shortened by a count left over from earlier.
- R6: Within one conversion `bit_strobe` pulses exactly NBITS times. `bit_idx` shows NBITS-1, NBITS-2, … down to 0 at those pulses in that order.
- R7: After the decision at index 0 the block runs one more settling wait of the same length. At its end `conv_stop` rises and `cmp_clk` stays low. `cmp_clk` and `conv_stop` are never high together.
- R8: `conv_stop` stays high while `samp_clk` stays low. It is low after the first edge at which `samp_clk` is sampled high.
- R9: If `samp_clk` is sampled high before `conv_stop` rises, `cmp_clk` is low after that edge, `bit_idx` returns to NBITS-1 and the next conversion starts from the first bit.
- R10: While the sequencer is idle, `cmp_done` has no effect: `cmp_clk` and `bit_strobe` stay 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| samp_clk | input | 1 | Sampling clock; conversion runs while low |
| cmp_done | input | 1 | Comparator decision-complete flag |
| dly_code | input | 5 | Settling-delay code |
| cmp_clk | output | 1 | Comparator clock |
| bit_strobe | output | 1 | High in the cycle a decision is reported |
| bit_idx | output | $clog2(NBITS) | Index of the bit being decided |
| conv_stop | output | 1 | End of conversion, margin cycle included |

## Verification
The hardest case to reach from the ports is a sampling-clock abort that lands part-way through a settling wait. The timer is then holding a partial count when the next conversion begins. The bench sets this up by walking two decisions into a conversion with a long code. It raises `samp_clk` a few ticks into the third wait, and then runs a full conversion in which every wait length is measured against the code.

A behavioural comparator with randomized response latency drives `cmp_done`, so each wait is measured from a different phase. A second abort while the comparator clock is high, and `cmp_done` toggled during idle, cover the other edges of the loop.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  localparam int CODE_W = 5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMP,
    ST_RST,
    ST_SETTLE,
    ST_STOP
  } loop_st_e;

  // Settling length in fast-clock ticks for a given delay code.
  function automatic int unsigned settle_ticks(input logic [CODE_W-1:0] code,
                                               input int unsigned base,
                                               input int unsigned step);
    return base + (int'(code) * step);
  endfunction

endpackage

// File: rtl/sar_settle_timer.sv
module sar_settle_timer #(
  parameter int TW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          run,
  input  logic [TW-1:0] target,
  output logic          expired
);

  logic [TW-1:0] cnt_q;

  assign expired = run && (cnt_q == (target - 1'b1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (run && !expired) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R4
  timer_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < target));

  // R5
  timer_fresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !run) |=> (cnt_q == '0));

endmodule

// File: rtl/sar_bit_counter.sv
module sar_bit_counter #(
  parameter int NBITS = 10,
  parameter int IW    = $clog2(NBITS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          dec,
  output logic [IW-1:0] idx,
  output logic          is_zero
);

  localparam logic [IW-1:0] TOP_IDX = IW'(NBITS - 1);

  logic [IW-1:0] idx_q;

  assign idx     = idx_q;
  assign is_zero = (idx_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= TOP_IDX;
    end else if (load) begin
      idx_q <= TOP_IDX;
    end else if (dec) begin
      idx_q <= idx_q - 1'b1;
    end
  end

  // R6
  idx_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> (idx_q != '0));

  // R6
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= TOP_IDX);

endmodule

// File: rtl/async_sar_sequencer.sv
module async_sar_sequencer
  import sar_seq_pkg::*;
#(
  parameter int NBITS      = 10,
  parameter int MIN_TICKS  = 4,
  parameter int STEP_TICKS = 2,
  localparam int IW        = $clog2(NBITS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              samp_clk,
  input  logic              cmp_done,
  input  logic [CODE_W-1:0] dly_code,
  output logic              cmp_clk,
  output logic              bit_strobe,
  output logic [IW-1:0]     bit_idx,
  output logic              conv_stop
);

  localparam int MAX_TICKS = MIN_TICKS + ((2 ** CODE_W) - 1) * STEP_TICKS;
  localparam int TW        = $clog2(MAX_TICKS + 1);

  loop_st_e st_q, st_d;
  logic     final_q;
  logic     cmp_clk_q, stop_q;

  // Named loop events
  logic start_lvl;
  logic launch_evt;
  logic decide_evt;
  logic release_evt;
  logic settle_end;
  logic idx_zero;
  logic [TW-1:0] wait_len;

  assign start_lvl   = ~samp_clk;
  assign launch_evt  = (st_q == ST_IDLE) && start_lvl;
  assign decide_evt  = (st_q == ST_CMP) && cmp_done;
  assign release_evt = (st_q == ST_RST) && !cmp_done;
  assign wait_len    = TW'(settle_ticks(dly_code, MIN_TICKS, STEP_TICKS));

  sar_settle_timer #(.TW(TW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (st_q != ST_SETTLE),
    .run     (st_q == ST_SETTLE),
    .target  (wait_len),
    .expired (settle_end)
  );

  sar_bit_counter #(.NBITS(NBITS), .IW(IW)) u_bits (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (launch_evt || !start_lvl),
    .dec     (decide_evt && !idx_zero),
    .idx     (bit_idx),
    .is_zero (idx_zero)
  );

  always_comb begin
    st_d = st_q;
    if (!start_lvl) begin
      st_d = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE:   st_d = ST_CMP;
        ST_CMP:    if (cmp_done)    st_d = ST_RST;
        ST_RST:    if (release_evt) st_d = ST_SETTLE;
        ST_SETTLE: if (settle_end)  st_d = final_q ? ST_STOP : ST_CMP;
        ST_STOP:   st_d = ST_STOP;
        default:   st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      final_q   <= 1'b0;
      cmp_clk_q <= 1'b0;
      stop_q    <= 1'b0;
    end else begin
      st_q      <= st_d;
      cmp_clk_q <= (st_d == ST_CMP);
      stop_q    <= (st_d == ST_STOP);
      if (!start_lvl || launch_evt) begin
        final_q <= 1'b0;
      end else if (decide_evt && idx_zero) begin
        final_q <= 1'b1;
      end
    end
  end

  assign cmp_clk    = cmp_clk_q;
  assign conv_stop  = stop_q;
  assign bit_strobe = decide_evt;

  // R2
  launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch_evt |=> cmp_clk);

  // R3
  strobe_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_strobe && !samp_clk) |=> !cmp_clk);

  // R7
  stop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmp_clk && conv_stop));

  // R8
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_stop && !samp_clk) |=> conv_stop);

  // R9
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    samp_clk |=> (!cmp_clk && !conv_stop));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) |-> !bit_strobe);

endmodule

// File: tb/tb_async_sar_sequencer.sv
module tb_async_sar_sequencer;

  localparam int CLK_PERIOD = 10;
  localparam int NB    = 10;
  localparam int MINT  = 4;
  localparam int STEPT = 2;
  localparam int IW    = $clog2(NB);

  typedef struct packed {
    logic [4:0] code;
    logic [3:0] lat_hi;
    logic [3:0] lat_lo;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{code: 5'd0,  lat_hi: 4'd1, lat_lo: 4'd0},
    '{code: 5'd31, lat_hi: 4'd3, lat_lo: 4'd2},
    '{code: 5'd5,  lat_hi: 4'd0, lat_lo: 4'd1},
    '{code: 5'd17, lat_hi: 4'd2, lat_lo: 4'd3},
    '{code: 5'd1,  lat_hi: 4'd4, lat_lo: 4'd0},
    '{code: 5'd12, lat_hi: 4'd1, lat_lo: 4'd1}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          samp_clk;
  logic          cmp_done;
  logic [4:0]    dly_code;
  logic          cmp_clk;
  logic          bit_strobe;
  logic [IW-1:0] bit_idx;
  logic          conv_stop;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  async_sar_sequencer #(.NBITS(NB), .MIN_TICKS(MINT), .STEP_TICKS(STEPT)) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .samp_clk   (samp_clk),
    .cmp_done   (cmp_done),
    .dly_code   (dly_code),
    .cmp_clk    (cmp_clk),
    .bit_strobe (bit_strobe),
    .bit_idx    (bit_idx),
    .conv_stop  (conv_stop)
  );

  // Expected wait: floor plus one step per code unit, summed step by step.
  function automatic int exp_wait(input logic [4:0] code);
    int t = MINT;
    for (int k = 0; k < int'(code); k++) t += STEPT;
    return t;
  endfunction

  task automatic chk(input bit ok, input string tag, input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d (t=%0t)", tag, got, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      errors++;
      $display("FAIL watchdog: got %0d cycles expected fewer than 150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // One full conversion with a behavioural comparator of random latency.
  task automatic run_conv(input logic [4:0] code, input int lat_hi, input int lat_lo);
    int d = exp_wait(code);
    int n;
    @(negedge clk);
    dly_code = code;
    samp_clk = 1'b0;
    @(negedge clk);
    chk(cmp_clk == 1'b1, "R2 launch cmp_clk", int'(cmp_clk), 1);
    for (int b = NB - 1; b >= 0; b--) begin
      repeat (lat_hi + int'($urandom_range(0, 2))) @(negedge clk);
      cmp_done = 1'b1;
      #1;
      chk(bit_strobe == 1'b1, "R3 strobe on decision", int'(bit_strobe), 1);
      chk(int'(bit_idx) == b, "R6 bit_idx order", int'(bit_idx), b);
      @(negedge clk);
      chk(cmp_clk == 1'b0, "R3 fast reset path", int'(cmp_clk), 0);
      chk(bit_strobe == 1'b0, "R3 strobe single cycle", int'(bit_strobe), 0);
      repeat (lat_lo) @(negedge clk);
      cmp_done = 1'b0;
      n = 0;
      while (!cmp_clk && !conv_stop && n < 300) begin
        @(negedge clk);
        n++;
      end
      chk(n == d + 1, "R4 settle length", n, d + 1);
      if (b == 0) begin
        chk(conv_stop && !cmp_clk, "R7 margin then stop", int'(conv_stop), 1);
      end else begin
        chk(cmp_clk && !conv_stop, "R7 no early stop", int'(cmp_clk), 1);
      end
    end
    repeat (3) @(negedge clk);
    chk(conv_stop == 1'b1, "R8 stop held", int'(conv_stop), 1);
    chk(cmp_clk == 1'b0, "R7 clock low at stop", int'(cmp_clk), 0);
    samp_clk = 1'b1;
    @(negedge clk);
    chk(conv_stop == 1'b0, "R8 stop release", int'(conv_stop), 0);
  endtask

  initial begin
    rst_n    = 1'b0;
    samp_clk = 1'b1;
    cmp_done = 1'b0;
    dly_code = 5'd0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(cmp_clk == 1'b0, "R1 cmp_clk reset", int'(cmp_clk), 0);
    chk(conv_stop == 1'b0, "R1 stop reset", int'(conv_stop), 0);
    chk(bit_strobe == 1'b0, "R1 strobe reset", int'(bit_strobe), 0);
    chk(int'(bit_idx) == NB - 1, "R1 idx reset", int'(bit_idx), NB - 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R10: comparator activity while idle
    cmp_done = 1'b1;
    #1;
    chk(bit_strobe == 1'b0, "R10 idle strobe", int'(bit_strobe), 0);
    repeat (3) @(negedge clk);
    chk(cmp_clk == 1'b0, "R10 idle clock", int'(cmp_clk), 0);
    cmp_done = 1'b0;
    @(negedge clk);

    // Table walk
    for (int v = 0; v < NV; v++) begin
      run_conv(VECS[v].code, int'(VECS[v].lat_hi), int'(VECS[v].lat_lo));
      repeat (2) @(negedge clk);
    end

    // R9/R5: abort during a settling wait
    dly_code = 5'd31;
    samp_clk = 1'b0;
    @(negedge clk);
    for (int b = 0; b < 2; b++) begin
      @(negedge clk);
      cmp_done = 1'b1;
      @(negedge clk);
      cmp_done = 1'b0;
      while (!cmp_clk) @(negedge clk);
    end
    @(negedge clk);
    cmp_done = 1'b1;
    @(negedge clk);
    cmp_done = 1'b0;
    repeat (5) @(negedge clk);
    samp_clk = 1'b1;
    @(negedge clk);
    chk(cmp_clk == 1'b0, "R9 abort clock", int'(cmp_clk), 0);
    chk(conv_stop == 1'b0, "R9 abort stop", int'(conv_stop), 0);
    chk(int'(bit_idx) == NB - 1, "R9 idx reload", int'(bit_idx), NB - 1);
    // R5: every wait of the next conversion is full length
    run_conv(5'd31, 1, 1);

    // R9: abort while the comparator clock is high
    @(negedge clk);
    samp_clk = 1'b0;
    @(negedge clk);
    chk(cmp_clk == 1'b1, "R2 relaunch", int'(cmp_clk), 1);
    samp_clk = 1'b1;
    @(negedge clk);
    chk(cmp_clk == 1'b0, "R9 abort in compare", int'(cmp_clk), 0);
    run_conv(5'd3, 0, 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule